// File: doc/BRIEF.md
# Half-Duplex Bus Transmitter with End-of-Frame Interrupt

This block is the transmit side of a serial port that masters a shared two-wire differential bus. Software pushes bytes into a 16-entry queue. Each byte carries a 2-bit parity mode, so an address byte and a data byte can be told apart by the level of their parity bit. A single state machine turns each queued byte into an 11-bit frame: a start bit, eight data bits sent LSB first, a parity bit and a stop bit. Every bit lasts 16 pulses of an external enable that runs at sixteen times the baud rate. The machine also drives the line-driver enable. It raises that enable one bit time before the first start bit of a burst and drops it when the burst has fully drained.

Two interrupt lines report progress. The queue-empty line shows that the queue can take more bytes. When a burst starts from idle, this line is held low until the first frame reaches its stop bit, so that it does not fire as soon as the lone byte moves into the shifter. The completion line is a level. It rises on the same edge on which the last stop bit ends. That edge also drops the driver enable and sets the shifter-empty flag. A line break can be requested only once the transmitter has drained, so a break never cuts a frame short.

States: IDLE (line high, driver off), LEAD (driver on, line high, one bit time), START, DATA, PAR, STOP and BRK (line held low). Transitions:
- IDLE→LEAD when the queue is non-empty.
- IDLE→BRK on an accepted break request.
- LEAD→START on the last tick of the lead bit, which pops the queue.
- START→DATA, then DATA→PAR after the eighth data bit, then PAR→STOP.
- STOP→START when the queue still holds a byte (back to back, popping it).
- STOP→IDLE when the queue is empty.
- BRK→IDLE after the programmed number of bit times.

Top module: `rs485_tx`

## Requirements
- R1: A frame on `txd_o` consists of a low start bit, then the 8 data bits LSB first, then the parity bit, then a high stop bit. Each bit lasts exactly 16 ticks of `tick16_i`.
- R2: The parity bit follows the entry's `wr_mode_i` code. Code 00 gives even parity (the XOR of the data). Code 01 gives odd parity. Code 10 forces the bit to 0 (data marking). Code 11 forces it to 1 (address marking).
- R3: The parity mode is stored with each queued byte. Queued bytes of different modes go out back to back, with no idle or lead time between their frames.
- R4: When a burst starts from idle, `de_o` rises and `txd_o` stays high for exactly 16 ticks before the start bit.
- R5: `tsr_empty_o` is high exactly when the queue is empty and no frame or break is in progress. While it is high, `txd_o` is 1 and `de_o` is 0. `de_o` falls on the same edge on which `tsr_empty_o` rises.
- R6: `irq_tc_o` rises on the edge that consumes the final tick of the last stop bit, or of a break. It stays high until an accepted write, a one-cycle pulse on `tc_clr_i` or an accepted break clears it.
- R7: `irq_thre_o` is high when the queue is empty. The exception is a burst started from idle: there it stays low until the first frame of the burst enters its stop bit.
- R8: The queue holds 16 bytes and `fifo_full_o` is high when all 16 slots are used. A write while the queue is full is dropped and never transmitted.
- R9: A break request is accepted in a cycle where `tsr_empty_o` is high and no write arrives. The break holds `txd_o` low with `de_o` high for `brk_len_i` bit times, with 0 treated as 1. `irq_tc_o` is raised at its end.
- R10: A break request made while a frame is pending or in progress is ignored. The frame is sent intact and no break follows.
- R11: After reset, `txd_o`=1, `de_o`=0, `tsr_empty_o`=1, `irq_tc_o`=0, `irq_thre_o`=1 and `fifo_full_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Enable pulse at 16x baud rate |
| wr_en_i | input | 1 | Queue write strobe |
| wr_data_i | input | 8 | Byte to queue |
| wr_mode_i | input | 2 | Parity mode of the byte (00 even, 01 odd, 10 force 0, 11 force 1) |
| tc_clr_i | input | 1 | Write-one-to-clear for the completion interrupt |
| brk_req_i | input | 1 | Break request |
| brk_len_i | input | 8 | Break length in bit times |
| txd_o | output | 1 | Serial line |
| de_o | output | 1 | Line-driver enable |
| fifo_full_o | output | 1 | Queue full |
| tsr_empty_o | output | 1 | Shifter and queue both empty |
| irq_thre_o | output | 1 | Queue-empty interrupt |
| irq_tc_o | output | 1 | Transmit-complete interrupt |

## Verification
The bench builds the block with its default parameters: 8 data bits, a 16-entry queue, 16 ticks per bit and an 8-bit break length. It pulses the tick enable every second clock, so a bit spans 32 clocks and the enable gating is exercised between pulses. With a depth of 16, a run of seventeen writes into an idle transmitter fills the queue before the first pop and tests the dropped write. The 16-tick bit makes the lead time, the stop-bit point at which the queue-empty interrupt is released, and the exact edge at which the completion interrupt rises all observable by counting ticks on the decoded line.

// File: rtl/rs485_tx_pkg.sv
`timescale 1ns/1ps
package rs485_tx_pkg;

    typedef enum logic [1:0] {
        PAR_EVEN = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_LOW  = 2'b10,
        PAR_HIGH = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } tx_state_e;

    function automatic logic parity_bit(input par_mode_e mode, input logic xor_red);
        logic r;
        unique case (mode)
            PAR_EVEN: r = xor_red;
            PAR_ODD:  r = ~xor_red;
            PAR_LOW:  r = 1'b0;
            PAR_HIGH: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rs485_tx_fifo.sv
`timescale 1ns/1ps
module rs485_tx_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_req_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic         accept_o,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] count_q;

    assign empty_o  = (count_q == '0);
    assign full_o   = (count_q == CW'(DEPTH));
    assign accept_o = wr_req_i && !full_o;
    assign dout_o   = mem_q[rptr_q];

    always_ff @(posedge clk) begin
        if (accept_o) mem_q[wptr_q] <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (accept_o) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            if (pop_i)    rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            unique case ({accept_o, pop_i})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && wr_req_i && !pop_i) |=> (full_o && $stable(wptr_q)));

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/rs485_tx_fsm.sv
`timescale 1ns/1ps
module rs485_tx_fsm
    import rs485_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int BRK_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              fifo_empty_i,
    input  logic              wr_acc_i,
    input  logic [DATA_W-1:0] ent_data_i,
    input  par_mode_e         ent_mode_i,
    input  logic              brk_req_i,
    input  logic [BRK_W-1:0]  brk_len_i,
    output logic              pop_o,
    output logic              txd_o,
    output logic              de_o,
    output logic              idle_o,
    output logic              done_o,
    output logic              lead_pop_o,
    output logic              stop_enter_o,
    output logic              brk_go_o
);
    localparam int TCW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int BIW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [TCW-1:0] TC_LAST  = TCW'(TICKS_PER_BIT - 1);
    localparam logic [BIW-1:0] BIT_LAST = BIW'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [TCW-1:0]    tcnt_q;
    logic [BIW-1:0]    bidx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    par_mode_e         mode_q;
    logic [BRK_W-1:0]  brk_cnt_q, brk_len_q;
    logic              bit_end, brk_last, load;

    assign bit_end  = tick_i && (tcnt_q == TC_LAST);
    assign brk_last = (brk_cnt_q == brk_len_q - 1'b1);

    // next state and transition strobes
    always_comb begin
        state_d      = state_q;
        pop_o        = 1'b0;
        load         = 1'b0;
        done_o       = 1'b0;
        lead_pop_o   = 1'b0;
        stop_enter_o = 1'b0;
        brk_go_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!fifo_empty_i) begin
                    state_d = ST_LEAD;
                end else if (brk_req_i && !wr_acc_i) begin
                    state_d  = ST_BRK;
                    brk_go_o = 1'b1;
                end
            end
            ST_LEAD: begin
                if (bit_end) begin
                    state_d    = ST_START;
                    pop_o      = 1'b1;
                    load       = 1'b1;
                    lead_pop_o = 1'b1;
                end
            end
            ST_START: begin
                if (bit_end) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && bidx_q == BIT_LAST) state_d = ST_PAR;
            end
            ST_PAR: begin
                if (bit_end) begin
                    state_d      = ST_STOP;
                    stop_enter_o = 1'b1;
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (!fifo_empty_i) begin
                        state_d = ST_START;
                        pop_o   = 1'b1;
                        load    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        done_o  = 1'b1;
                    end
                end
            end
            ST_BRK: begin
                if (bit_end && brk_last) begin
                    state_d = ST_IDLE;
                    done_o  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit timing and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q    <= '0;
            bidx_q    <= '0;
            shreg_q   <= '0;
            par_q     <= 1'b0;
            mode_q    <= PAR_EVEN;
            brk_cnt_q <= '0;
            brk_len_q <= BRK_W'(1);
        end else begin
            if (state_q == ST_IDLE) tcnt_q <= '0;
            else if (tick_i)        tcnt_q <= bit_end ? '0 : tcnt_q + 1'b1;

            if (state_q == ST_START)                bidx_q <= '0;
            else if (state_q == ST_DATA && bit_end) bidx_q <= bidx_q + 1'b1;

            if (load) begin
                shreg_q <= ent_data_i;
                mode_q  <= ent_mode_i;
                par_q   <= parity_bit(ent_mode_i, ^ent_data_i);
            end else if (state_q == ST_DATA && bit_end) begin
                shreg_q <= shreg_q >> 1;
            end

            if (brk_go_o) begin
                brk_cnt_q <= '0;
                brk_len_q <= (brk_len_i == '0) ? BRK_W'(1) : brk_len_i;
            end else if (state_q == ST_BRK && bit_end) begin
                brk_cnt_q <= brk_cnt_q + 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        txd_o  = 1'b1;
        de_o   = 1'b1;
        idle_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin de_o = 1'b0; idle_o = 1'b1; end
            ST_LEAD:  txd_o = 1'b1;
            ST_START: txd_o = 1'b0;
            ST_DATA:  txd_o = shreg_q[0];
            ST_PAR:   txd_o = par_q;
            ST_STOP:  txd_o = 1'b1;
            ST_BRK:   txd_o = 1'b0;
            default:  begin de_o = 1'b0; idle_o = 1'b1; end
        endcase
    end

    assert_stick_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAR && mode_q == PAR_HIGH) |-> txd_o);

    assert_stick_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAR && mode_q == PAR_LOW) |-> !txd_o);

    assert_stop_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> (txd_o && de_o));

endmodule

// File: rtl/rs485_tx_irq.sv
`timescale 1ns/1ps
module rs485_tx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    input  logic fifo_empty_i,
    input  logic wr_acc_i,
    input  logic clr_i,
    input  logic done_i,
    input  logic brk_go_i,
    input  logic lead_pop_i,
    input  logic stop_enter_i,
    output logic tsr_empty_o,
    output logic irq_tc_o,
    output logic irq_thre_o
);
    logic hold_q;
    logic tc_q;

    assign tsr_empty_o = idle_i && fifo_empty_i;
    assign irq_tc_o    = tc_q;
    assign irq_thre_o  = fifo_empty_i && !hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q   <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (wr_acc_i || clr_i || brk_go_i) tc_q <= 1'b0;
            else if (done_i)                     tc_q <= 1'b1;

            if (lead_pop_i)        hold_q <= 1'b1;
            else if (stop_enter_i) hold_q <= 1'b0;
        end
    end

    assert_tc_cleared_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc_i |=> !irq_tc_o);

    assert_thre_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lead_pop_i |=> !irq_thre_o);

endmodule

// File: rtl/rs485_tx.sv
`timescale 1ns/1ps
module rs485_tx
    import rs485_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int FIFO_DEPTH    = 16,
    parameter int TICKS_PER_BIT = 16,
    parameter int BRK_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        wr_mode_i,
    input  logic              tc_clr_i,
    input  logic              brk_req_i,
    input  logic [BRK_W-1:0]  brk_len_i,
    output logic              txd_o,
    output logic              de_o,
    output logic              fifo_full_o,
    output logic              tsr_empty_o,
    output logic              irq_thre_o,
    output logic              irq_tc_o
);
    localparam int ENT_W = DATA_W + 2;

    logic             wr_acc, pop, fifo_empty;
    logic [ENT_W-1:0] ent;
    logic             idle, done, lead_pop, stop_enter, brk_go;

    rs485_tx_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req_i (wr_en_i),
        .din_i    ({wr_mode_i, wr_data_i}),
        .pop_i    (pop),
        .accept_o (wr_acc),
        .dout_o   (ent),
        .empty_o  (fifo_empty),
        .full_o   (fifo_full_o)
    );

    rs485_tx_fsm #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT), .BRK_W(BRK_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick16_i),
        .fifo_empty_i (fifo_empty),
        .wr_acc_i     (wr_acc),
        .ent_data_i   (ent[DATA_W-1:0]),
        .ent_mode_i   (par_mode_e'(ent[ENT_W-1:DATA_W])),
        .brk_req_i    (brk_req_i),
        .brk_len_i    (brk_len_i),
        .pop_o        (pop),
        .txd_o        (txd_o),
        .de_o         (de_o),
        .idle_o       (idle),
        .done_o       (done),
        .lead_pop_o   (lead_pop),
        .stop_enter_o (stop_enter),
        .brk_go_o     (brk_go)
    );

    rs485_tx_irq u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_i       (idle),
        .fifo_empty_i (fifo_empty),
        .wr_acc_i     (wr_acc),
        .clr_i        (tc_clr_i),
        .done_i       (done),
        .brk_go_i     (brk_go),
        .lead_pop_i   (lead_pop),
        .stop_enter_i (stop_enter),
        .tsr_empty_o  (tsr_empty_o),
        .irq_tc_o     (irq_tc_o),
        .irq_thre_o   (irq_thre_o)
    );

    assert_de_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de_o) |-> tsr_empty_o);

    assert_idle_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tsr_empty_o |-> (txd_o && !de_o));

    assert_tc_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tc_o |-> tsr_empty_o);

    assert_thre_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_thre_o |-> fifo_empty);

    assert_brk_only_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(de_o) && !txd_o) |-> $past(tsr_empty_o));

endmodule

// File: tb/rs485_tx_bench.sv
`timescale 1ns/1ps
module rs485_tx_bench;
    localparam int TDIV        = 2;
    localparam int TPB         = 16;
    localparam int FRAME_TICKS = 11 * TPB;
    localparam int NVEC        = 8;
    // {mode[1:0], data[7:0], expected parity}
    localparam logic [10:0] VEC [NVEC] = '{
        {2'b11, 8'hA5, 1'b1},
        {2'b10, 8'hFF, 1'b0},
        {2'b00, 8'h01, 1'b1},
        {2'b00, 8'h03, 1'b0},
        {2'b01, 8'h03, 1'b1},
        {2'b01, 8'h07, 1'b0},
        {2'b11, 8'h00, 1'b1},
        {2'b10, 8'h80, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic wr_en = 1'b0, tc_clr = 1'b0, brk_req = 1'b0;
    logic [7:0] wr_data = '0, brk_len = '0;
    logic [1:0] wr_mode = '0;
    logic txd, de, full, tsr_empty, irq_thre, irq_tc;
    int vectors = 0, miscompares = 0, tdiv = 0;

    always #2 clk = ~clk;

    rs485_tx u_rs485_tx (
        .clk(clk), .rst_n(rst_n), .tick16_i(tick), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .wr_mode_i(wr_mode), .tc_clr_i(tc_clr),
        .brk_req_i(brk_req), .brk_len_i(brk_len), .txd_o(txd), .de_o(de),
        .fifo_full_o(full), .tsr_empty_o(tsr_empty), .irq_thre_o(irq_thre),
        .irq_tc_o(irq_tc)
    );

    initial begin
        forever begin
            @(negedge clk);
            tdiv = (tdiv + 1) % TDIV;
            tick = (tdiv == 0);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] mode, input logic [7:0] data);
        wr_en = 1'b1; wr_mode = mode; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rx_frame(output logic [7:0] d, output logic p, output logic s,
                            output int lead, output logic th_a, output logic th_b,
                            output logic de_end, output logic tc_end);
        int k;
        lead = 0; d = '0; p = 1'b0; s = 1'b0;
        th_a = 1'b0; th_b = 1'b0; de_end = 1'b0; tc_end = 1'b0;
        while (txd !== 1'b0) begin
            if (tick && de && txd) lead++;
            step();
        end
        k = 0;
        while (k < FRAME_TICKS) begin
            if (tick) begin
                if (k % TPB == TPB / 2) begin
                    if (k / TPB >= 1 && k / TPB <= 8) d[k / TPB - 1] = txd;
                    if (k / TPB == 9)  p = txd;
                    if (k / TPB == 10) s = txd;
                end
                if (k == 9 * TPB + TPB - 1) th_a = irq_thre;
                if (k == 10 * TPB)          th_b = irq_thre;
                if (k == FRAME_TICKS - 1) begin de_end = de; tc_end = irq_tc; end
                k++;
            end
            if (k < FRAME_TICKS) step();
        end
    endtask

    initial begin
        #600000;
        miscompares++;
        vectors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic p, s, tha, thb, dee, tce;
        int lead, n;

        repeat (5) step();
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk("R11 txd", txd, 1); chk("R11 de", de, 0);
        chk("R11 tsr_empty", tsr_empty, 1); chk("R11 irq_tc", irq_tc, 0);
        chk("R11 irq_thre", irq_thre, 1); chk("R11 full", full, 0);

        // table-driven single-byte frames
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][10:9], VEC[i][8:1]);
            chk("R6 cleared by write", irq_tc, 0);
            rx_frame(d, p, s, lead, tha, thb, dee, tce);
            chk("R1 data", d, VEC[i][8:1]);
            chk("R2 parity", p, VEC[i][0]);
            chk("R1 stop", s, 1);
            chk("R4 lead ticks", lead, TPB);
            chk("R7 thre held before stop", tha, 0);
            chk("R7 thre at stop", thb, 1);
            chk("R6 tc before last tick", {dee, tce}, 2'b10);
            step();
            chk("R6 tc at end of stop", irq_tc, 1);
            chk("R5 de released", de, 0);
            chk("R5 tsr_empty", tsr_empty, 1);
            repeat (3) step();
        end

        // R6 write-one-to-clear
        tc_clr = 1'b1; step(); tc_clr = 1'b0;
        chk("R6 w1c", irq_tc, 0);
        chk("R5 tsr_empty after clear", tsr_empty, 1);

        // R3 back-to-back burst with mixed modes
        wr(2'b11, 8'h12); wr(2'b10, 8'h34); wr(2'b10, 8'h56);
        chk("R5 busy flag", tsr_empty, 0);
        rx_frame(d, p, s, lead, tha, thb, dee, tce);
        chk("R3 addr data", d, 8'h12); chk("R3 addr parity", p, 1);
        step();
        chk("R6 no tc mid burst", irq_tc, 0); chk("R5 de mid burst", de, 1);
        rx_frame(d, p, s, lead, tha, thb, dee, tce);
        chk("R3 no gap", lead, 0);
        chk("R3 data byte", d, 8'h34); chk("R3 data parity", p, 0);
        step();
        rx_frame(d, p, s, lead, tha, thb, dee, tce);
        chk("R3 third byte", d, 8'h56); chk("R3 third parity", p, 0);
        step();
        chk("R6 tc after burst", irq_tc, 1); chk("R5 de after burst", de, 0);

        // R8 queue full, seventeenth write dropped
        for (int i = 0; i < 17; i++) wr(2'b10, 8'(8'h40 + i));
        chk("R8 full", full, 1);
        for (int i = 0; i < 16; i++) begin
            rx_frame(d, p, s, lead, tha, thb, dee, tce);
            chk("R8 queued byte", d, 8'h40 + i);
            step();
        end
        chk("R8 drained", tsr_empty, 1);
        n = 0;
        for (int i = 0; i < 3 * TPB * TDIV; i++) begin
            if (txd !== 1'b1 || de !== 1'b0) n++;
            step();
        end
        chk("R8 dropped byte not sent", n, 0);

        // R9 break of 3 bit times
        brk_len = 8'd3; brk_req = 1'b1; step(); brk_req = 1'b0;
        chk("R6 cleared by break", irq_tc, 0);
        chk("R9 break drives", {txd, de}, 2'b01);
        n = 0;
        while (txd === 1'b0) begin if (tick) n++; step(); end
        chk("R9 break length", n, 3 * TPB);
        chk("R9 tc after break", irq_tc, 1); chk("R9 de after break", de, 0);

        // R9 zero length treated as one bit
        brk_len = 8'd0; brk_req = 1'b1; step(); brk_req = 1'b0;
        n = 0;
        while (txd === 1'b0) begin if (tick) n++; step(); end
        chk("R9 zero length", n, TPB);

        // R10 break ignored while busy
        wr(2'b10, 8'h5A);
        repeat (10) step();
        brk_len = 8'd4; brk_req = 1'b1; step(); brk_req = 1'b0;
        rx_frame(d, p, s, lead, tha, thb, dee, tce);
        chk("R10 frame intact", d, 8'h5A);
        step();
        chk("R10 tc", irq_tc, 1);
        n = 0;
        for (int i = 0; i < 3 * TPB * TDIV; i++) begin
            if (txd !== 1'b1) n++;
            step();
        end
        chk("R10 no break after frame", n, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule